// File: doc/BRIEF.md
# SD Command CRC7 Generator

This block produces the 7-bit checksum that protects an SD-card command. The caller presents the 40 leading bits of the command: start bit, transmission bit, six-bit index and 32-bit argument, most significant bit first. It pulses a one-cycle load strobe with that word. The block latches the word and walks through it one bit per clock. When the checksum is on the output, it raises a valid flag.

The surrounding logic appends the checksum and a closing 1 bit to form the 48-bit command. For example, an index-0 command with a zero argument ends in the byte 0x95. Framing, line driving and response checking belong to other blocks.

Top module: `sd_cmd_crc7_gen`

## Requirements
- R1: While reset is high, the next clock edge leaves `crc_valid_o` at 0 and `crc_o` at 0.
- R2: The result is the CRC with generator x^7 + x^3 + 1. The register starts at zero, and the 40 word bits are fed in from bit 39 down to bit 0. The input word is laid out as {1'b0, 1'b1, index[5:0], argument[31:0]}, and the final frame byte is {crc_o, 1'b1}. Examples of that final byte: index 0 with argument 0 gives 0x95, index 8 with argument 0x000001AA gives 0x87, index 55 with argument 0 gives 0x65, and index 41 with argument 0x40180000 gives 0x19.
- R3: Sampled after the clock edge that sees `load_i` high, `crc_valid_o` is 0.
- R4: After the load edge, `crc_valid_o` stays 0 for the next 39 edges and becomes 1 on the 40th edge (DATA_W edges after the load).
- R5: While `crc_valid_o` is 1 and no load arrives, `crc_valid_o` stays 1 and `crc_o` keeps its value.
- R6: A load that arrives during a computation abandons that computation. The result and the R4 timing then follow the new word and the new load edge.
- R7: `crc_o` changes only on the edge where `crc_valid_o` rises. During a computation it keeps the previous result.
- R8: Each load starts from a zero register, so a result never depends on earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | One-cycle strobe that captures `cmd_word_i` and starts a computation |
| cmd_word_i | input | 40 | Leading 40 command bits, MSB first |
| crc_o | output | 7 | Registered checksum result |
| crc_valid_o | output | 1 | High when `crc_o` holds the checksum of the last loaded word |

## Verification
On every cycle the assertions check the reset state and the clearing of valid by a load. They also check the exact distance from a load to the rise of valid, the stability of a finished result, and that the output never changes except at completion. Those properties do not show that the checksum value itself is correct. The bench's directed vectors and random words, checked against its own bitwise model, cover the values. The bench also covers restarts in mid-computation and loads that arrive while a result is being held.

// File: rtl/sd_crc7_pkg.sv
package sd_crc7_pkg;
  localparam int CMD_BITS    = 40;
  localparam int CHK_BITS    = 7;
  localparam logic [CHK_BITS-1:0] GEN_POLY = 7'h09;  // x^7 + x^3 + 1, x^7 implied
endpackage

// File: rtl/sd_crc_word_shifter.sv
module sd_crc_word_shifter #(
  parameter int DATA_W = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              advance,
  input  logic [DATA_W-1:0] word_in,
  output logic              head_bit
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (capture) begin
      word_q <= word_in;
    end else if (advance) begin
      word_q <= {word_q[DATA_W-2:0], 1'b0};
    end
  end

  assign head_bit = word_q[DATA_W-1];
endmodule

// File: rtl/sd_crc_bit_counter.sv
module sd_crc_bit_counter #(
  parameter int DATA_W = 40,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic advance,
  output logic last
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (advance && (cnt_q != LAST_IDX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/sd_crc_lfsr.sv
module sd_crc_lfsr #(
  parameter int CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic             data_bit,
  output logic [CRC_W-1:0] state,
  output logic [CRC_W-1:0] state_next
);
  logic [CRC_W-1:0] state_q;
  logic             fb;

  assign fb = state_q[CRC_W-1] ^ data_bit;

  for (genvar i = 0; i < CRC_W; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign state_next[i] = POLY[i] & fb;
    end else begin : g_up
      assign state_next[i] = state_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= '0;
    end else if (step) begin
      state_q <= state_next;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/sd_cmd_crc7_gen.sv
module sd_cmd_crc7_gen
  import sd_crc7_pkg::*;
#(
  parameter int DATA_W = CMD_BITS,
  parameter int CRC_W  = CHK_BITS,
  parameter logic [CRC_W-1:0] POLY = GEN_POLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] cmd_word_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_valid_o
);
  logic             busy_q;
  logic             head_bit;
  logic             last_bit;
  logic             step;
  logic [CRC_W-1:0] lfsr_state;
  logic [CRC_W-1:0] lfsr_next;

  assign step = busy_q && !load_i;

  sd_crc_word_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .capture(load_i), .advance(step),
    .word_in(cmd_word_i), .head_bit(head_bit)
  );

  sd_crc_bit_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(load_i), .advance(step), .last(last_bit)
  );

  sd_crc_lfsr #(.CRC_W(CRC_W), .POLY(POLY)) u_lfsr (
    .clk(clk), .rst(rst), .clear(load_i), .step(step), .data_bit(head_bit),
    .state(lfsr_state), .state_next(lfsr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      crc_valid_o <= 1'b0;
      crc_o       <= '0;
    end else if (load_i) begin
      busy_q      <= 1'b1;
      crc_valid_o <= 1'b0;
    end else if (step && last_bit) begin
      busy_q      <= 1'b0;
      crc_valid_o <= 1'b1;
      crc_o       <= lfsr_next;
    end
  end
endmodule

// File: rtl/sd_cmd_crc7_gen_chk.sv
module sd_cmd_crc7_gen_chk #(
  parameter int DATA_W = 40,
  parameter int CRC_W  = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             load_i,
  input logic [CRC_W-1:0] crc_o,
  input logic             crc_valid_o
);
  localparam int SL_W = $clog2(DATA_W + 2);
  localparam logic [SL_W-1:0] SL_MAX = SL_W'(DATA_W + 1);
  localparam logic [SL_W-1:0] SL_DONE = SL_W'(DATA_W);

  logic [SL_W-1:0] since_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_load <= SL_MAX;
    end else if (load_i) begin
      since_load <= '0;
    end else if (since_load != SL_MAX) begin
      since_load <= since_load + 1'b1;
    end
  end

  // R1
  rst_state_chk: assert property (@(posedge clk) rst |=> (!crc_valid_o && crc_o == '0));

  // R3
  load_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !crc_valid_o);

  // R4
  valid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_valid_o) |-> (since_load == SL_DONE));

  // R4
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (since_load < SL_DONE) |-> !crc_valid_o);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (crc_valid_o && !load_i) |=> (crc_valid_o && $stable(crc_o)));

  // R7
  crc_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_o) |-> $rose(crc_valid_o));
endmodule

bind sd_cmd_crc7_gen sd_cmd_crc7_gen_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .crc_o(crc_o), .crc_valid_o(crc_valid_o)
);

// File: tb/sd_cmd_crc7_gen_tb_top.sv
`timescale 1ns/1ps
module sd_cmd_crc7_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [39:0] cmd_word_i = '0;
  logic [6:0]  crc_o;
  logic        crc_valid_o;

  int total = 0;
  int bad   = 0;
  logic [6:0] prev_res = 7'h00;

  always #5 clk = ~clk;

  sd_cmd_crc7_gen dut_i (
    .clk(clk), .rst(rst), .load_i(load_i), .cmd_word_i(cmd_word_i),
    .crc_o(crc_o), .crc_valid_o(crc_valid_o)
  );

  function automatic logic [6:0] ref_crc(input logic [39:0] w);
    logic [6:0] c = 7'h00;
    logic fb;
    for (int i = 39; i >= 0; i--) begin
      fb = c[6] ^ w[i];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [39:0] mk_word(input logic [5:0] idx, input logic [31:0] arg);
    return {1'b0, 1'b1, idx, arg};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives a load and returns at the falling edge just after the load edge.
  task automatic pulse_load(input logic [39:0] w);
    @(negedge clk);
    load_i = 1'b1;
    cmd_word_i = w;
    @(negedge clk);
    load_i = 1'b0;
    cmd_word_i = $urandom;
  endtask

  task automatic run_word(input logic [39:0] w);
    logic [6:0] exp = ref_crc(w);
    pulse_load(w);
    check("R3", {31'd0, crc_valid_o}, 32'd0);
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k < 40) begin
        check("R4", {31'd0, crc_valid_o}, 32'd0);
        check("R7", {25'd0, crc_o}, {25'd0, prev_res});
      end
    end
    check("R4", {31'd0, crc_valid_o}, 32'd1);
    check("R2 R8", {25'd0, crc_o}, {25'd0, exp});
    prev_res = exp;
  endtask

  task automatic run_all();
    logic [39:0] wa;
    logic [39:0] wb;
    int idle;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    @(negedge clk);
    check("R1", {31'd0, crc_valid_o}, 32'd0);
    check("R1", {25'd0, crc_o}, 32'd0);
    rst = 1'b0;

    run_word(mk_word(6'd0, 32'h0));
    check("R2", {24'd0, crc_o, 1'b1}, 32'h95);
    run_word(mk_word(6'd8, 32'h000001AA));
    check("R2", {24'd0, crc_o, 1'b1}, 32'h87);
    run_word(mk_word(6'd55, 32'h0));
    check("R2", {24'd0, crc_o, 1'b1}, 32'h65);
    run_word(mk_word(6'd41, 32'h40180000));
    check("R2", {24'd0, crc_o, 1'b1}, 32'h19);

    idle = 7;
    repeat (idle) @(negedge clk);
    check("R5", {31'd0, crc_valid_o}, 32'd1);
    check("R5", {25'd0, crc_o}, 32'h0C);

    for (int t = 0; t < 3; t++) begin
      wa = {$urandom, $urandom};
      wb = {$urandom, $urandom};
      pulse_load(wa);
      repeat (3 + t * 15) @(negedge clk);
      check("R6", {31'd0, crc_valid_o}, 32'd0);
      run_word(wb);
      check("R6", {25'd0, crc_o}, {25'd0, ref_crc(wb)});
    end

    run_word(40'hFF_FFFF_FFFF);
    run_word(40'h00_0000_0000);
    run_word(40'h80_0000_0001);

    for (int t = 0; t < 25; t++) begin
      wa = {$urandom, $urandom};
      if (t % 2 == 0) wa = mk_word(6'($urandom), $urandom);
      run_word(wa);
      idle = $urandom_range(0, 4);
      repeat (idle) @(negedge clk);
      check("R5", {31'd0, crc_valid_o}, 32'd1);
      check("R5", {25'd0, crc_o}, {25'd0, prev_res});
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R4 watchdog actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule